// File: doc/BRIEF.md
# Microcontroller Reset Source Controller

This block gathers every reset request of a small 8-bit microcontroller core and turns them into one synchronous core reset and a restart request. Four sources feed it: an asynchronous external reset pin, the power-on reset of the chip (which is also the block's own asynchronous reset), a software-reset control bit held in a special function register, and a reset request from the brown-out handler.

For each reset event it emits a single-cycle strobe that returns the special function registers to their defaults, a preserve mask telling that register file which bits to spare, and a program-counter load of the restart address 0000h. It also keeps a power-on flag that software can read and clear. The external pin is brought into the clock domain through two flip-flops and is only believed after it has stayed high for a whole number of machine cycles.

Sources that are active together, or that arrive while another source is still holding the core in reset, fold into the reset already in progress. Data RAM has no connection to this block, so no reset can touch its contents.

Top module: `rst_source_ctrl`

## Requirements
- R1: The reset pin takes effect only after its synchronised level has been high for QUAL_CLKS = MC_CLKS*MIN_MC (default 12*2 = 24) consecutive clocks. A pulse that is shorter, or that drops low even once, produces no reset, and the count starts again from zero.
- R2: The pin passes through two synchroniser flops. With the pin held high, `core_rst` rises 26 clocks after the first edge that samples it. `core_rst` stays high while the pin stays high, and falls on the third edge after the pin is first sampled low.
- R3: A software reset fires on a 0-to-1 change of `swr_bit`. It gives `core_rst` for exactly one cycle, on the edge that first samples the bit high. Keeping the bit high causes no further reset.
- R4: `sfr_keep` bit 0 tells the register file to preserve the software-reset bit, and bit 1 tells it to preserve the watchdog status bit. Both bits are 1 on an event caused only by the software reset and 0 on every other event. The mask is non-zero only while `sfr_rst_stb` is high.
- R5: Every reset event produces exactly one cycle in which `pc_load` and `sfr_rst_stb` are high together with `core_rst`, with `pc_vec` = 16'h0000. This cycle is the first cycle of that `core_rst` interval.
- R6: Sources active in the same cycle, or arriving while `core_rst` is already held, merge into one event with one vector load and an all-zero keep mask.
- R7: While `bod_req` is high, `core_rst` is high. It goes high one clock after `bod_req` rises and low one clock after `bod_req` falls.
- R8: While `por_n` is low, `core_rst` is 1, `pof` is 1 and `pc_load` is 0. After release, one event follows on the first edge, and `core_rst` falls one edge later.
- R9: `pof` is cleared only by `pof_clr`, one clock after it is sampled high. No pin, software or brown-out reset changes `pof`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por_n | input | 1 | Power-on reset, asynchronous active low |
| rst_pin | input | 1 | External reset pin, asynchronous, active high |
| swr_bit | input | 1 | Software-reset control bit from the register file |
| bod_req | input | 1 | Brown-out reset request, synchronous level |
| pof_clr | input | 1 | Software clear of the power-on flag |
| core_rst | output | 1 | Synchronous core reset, active high |
| sfr_rst_stb | output | 1 | One-cycle register-file default strobe |
| sfr_keep | output | 2 | Preserve mask: bit 0 software-reset bit, bit 1 watchdog status |
| pc_load | output | 1 | One-cycle program-counter load |
| pc_vec | output | 16 | Restart address, 16'h0000 |
| pof | output | 1 | Power-on flag |

## Verification
The bench drives pin pulses of exactly 23 and 24 qualification clocks. A counter that is off by one would reset on the short pulse or miss the long one. It also drives a 20-high, 2-low, 20-high pattern, which catches a counter that pauses instead of restarting.

A software bit held high for many cycles would expose a level-triggered reset. A software edge that lands during a brown-out hold would expose a design that emits a second vector load. Software reset and brown-out asserted in the same cycle would show up as a preserve mask wrongly left set.

The power-on flag is cleared and then a brown-out reset is applied, to catch a design that sets the flag again on any reset.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

  // Reset requests seen in one cycle
  typedef struct packed {
    logic por;
    logic pin;
    logic bod;
    logic swr;
  } rst_src_t;

  localparam int unsigned KEEP_W       = 2;
  localparam int unsigned KEEP_SWR_BIT = 0;
  localparam int unsigned KEEP_WDT_BIT = 1;

  function automatic logic any_src(input rst_src_t s);
    return s.por | s.pin | s.bod | s.swr;
  endfunction

  function automatic logic soft_only(input rst_src_t s);
    return s.swr & ~(s.por | s.pin | s.bod);
  endfunction

endpackage

// File: rtl/rsc_pin_qual.sv
module rsc_pin_qual #(
  parameter int unsigned QUAL_CLKS = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  output logic pin_sync,
  output logic pin_hold
);
  localparam int unsigned CW = (QUAL_CLKS > 2) ? $clog2(QUAL_CLKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(QUAL_CLKS - 1);

  logic          meta_q;
  logic          sync_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_nxt;
  logic          cnt_en;

  // two-flop synchroniser
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= pin_async;
      sync_q <= meta_q;
    end
  end

  // qualification counter: restarts on any low cycle, saturates at LAST
  always_comb begin
    cnt_en  = 1'b0;
    cnt_nxt = cnt_q;
    if (!sync_q) begin
      cnt_en  = (cnt_q != '0);
      cnt_nxt = '0;
    end else if (cnt_q != LAST) begin
      cnt_en  = 1'b1;
      cnt_nxt = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_nxt;
    end
  end

  assign pin_sync = sync_q;
  assign pin_hold = sync_q & (cnt_q == LAST);

endmodule

// File: rtl/rsc_swr_edge.sv
module rsc_swr_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic swr_bit,
  output logic swr_rise
);
  logic last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= 1'b0;
    end else begin
      last_q <= swr_bit;
    end
  end

  assign swr_rise = swr_bit & ~last_q;

endmodule

// File: rtl/rsc_por_track.sv
module rsc_por_track (
  input  logic clk,
  input  logic rst_n,
  input  logic pof_clr,
  output logic por_pend,
  output logic pof
);
  logic pend_q;
  logic pof_q;
  logic pof_en;

  assign pof_en = pof_clr & pof_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b1;
    end else if (pend_q) begin
      pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pof_q <= 1'b1;
    end else if (pof_en) begin
      pof_q <= 1'b0;
    end
  end

  assign por_pend = pend_q;
  assign pof      = pof_q;

endmodule

// File: rtl/rsc_merge.sv
module rsc_merge
  import rsc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  rst_src_t          src,
  output logic              core_rst,
  output logic              evt,
  output logic [KEEP_W-1:0] keep
);
  logic              req_any;
  logic              evt_nxt;
  logic [KEEP_W-1:0] keep_nxt;
  logic              hold_q;
  logic              prev_q;
  logic              evt_q;
  logic [KEEP_W-1:0] keep_q;

  always_comb begin
    req_any  = any_src(src);
    evt_nxt  = req_any & ~prev_q;
    keep_nxt = '0;
    if (evt_nxt && soft_only(src)) begin
      keep_nxt[KEEP_SWR_BIT] = 1'b1;
      keep_nxt[KEEP_WDT_BIT] = 1'b1;
    end
  end

  // core reset is held from power-on; the edge tracker starts clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b1;
      prev_q <= 1'b0;
      evt_q  <= 1'b0;
      keep_q <= '0;
    end else begin
      hold_q <= req_any;
      prev_q <= req_any;
      evt_q  <= evt_nxt;
      keep_q <= keep_nxt;
    end
  end

  assign core_rst = hold_q;
  assign evt      = evt_q;
  assign keep     = keep_q;

endmodule

// File: rtl/rst_source_ctrl.sv
module rst_source_ctrl
  import rsc_pkg::*;
#(
  parameter int unsigned MC_CLKS   = 12,
  parameter int unsigned MIN_MC    = 2,
  parameter int unsigned VEC_W     = 16,
  parameter logic [15:0] RESET_VEC = 16'h0000
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_pin,
  input  logic              swr_bit,
  input  logic              bod_req,
  input  logic              pof_clr,
  output logic              core_rst,
  output logic              sfr_rst_stb,
  output logic [KEEP_W-1:0] sfr_keep,
  output logic              pc_load,
  output logic [VEC_W-1:0]  pc_vec,
  output logic              pof
);
  localparam int unsigned QUAL_CLKS = MC_CLKS * MIN_MC;

  logic     pin_sync;
  logic     pin_hold;
  logic     swr_rise;
  logic     por_pend;
  logic     evt;
  rst_src_t src;

  rsc_pin_qual #(.QUAL_CLKS(QUAL_CLKS)) u_pin (
    .clk      (clk),
    .rst_n    (por_n),
    .pin_async(rst_pin),
    .pin_sync (pin_sync),
    .pin_hold (pin_hold)
  );

  rsc_swr_edge u_swr (
    .clk     (clk),
    .rst_n   (por_n),
    .swr_bit (swr_bit),
    .swr_rise(swr_rise)
  );

  rsc_por_track u_por (
    .clk     (clk),
    .rst_n   (por_n),
    .pof_clr (pof_clr),
    .por_pend(por_pend),
    .pof     (pof)
  );

  always_comb begin
    src.por = por_pend;
    src.pin = pin_hold;
    src.bod = bod_req;
    src.swr = swr_rise;
  end

  rsc_merge u_merge (
    .clk     (clk),
    .rst_n   (por_n),
    .src     (src),
    .core_rst(core_rst),
    .evt     (evt),
    .keep    (sfr_keep)
  );

  assign sfr_rst_stb = evt;
  assign pc_load     = evt;
  assign pc_vec      = VEC_W'(RESET_VEC);

endmodule

// File: rtl/rst_source_ctrl_chk.sv
module rst_source_ctrl_chk #(
  parameter int unsigned QUAL_CLKS = 24
) (
  input logic       clk,
  input logic       por_n,
  input logic       pin_sync,
  input logic       swr_bit,
  input logic       bod_req,
  input logic       pof_clr,
  input logic       core_rst,
  input logic       sfr_rst_stb,
  input logic [1:0] sfr_keep,
  input logic       pc_load,
  input logic       pof
);
  localparam int unsigned RW = $clog2(QUAL_CLKS + 1);
  localparam logic [RW-1:0] RMAX = RW'(QUAL_CLKS);

  logic [RW-1:0] run_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      run_q <= '0;
    end else if (!pin_sync) begin
      run_q <= '0;
    end else if (run_q != RMAX) begin
      run_q <= run_q + 1'b1;
    end
  end

  // R1: a fresh reset needs a qualified pin, a brown-out or a software edge
  a_r1_pin_qualified: assert property (@(posedge clk) disable iff (!por_n)
    $rose(core_rst) |-> ($past(bod_req) || ($past(swr_bit) && !$past(swr_bit, 2)) ||
                         ($past(pin_sync) && ($past(run_q) >= RW'(QUAL_CLKS - 1)))));

  // R5: the vector load is a single cycle inside a reset
  a_r5_single_load: assert property (@(posedge clk) disable iff (!por_n)
    pc_load |=> !pc_load);

  a_r5_load_in_reset: assert property (@(posedge clk) disable iff (!por_n)
    pc_load |-> (core_rst && sfr_rst_stb));

  // R4: the preserve mask only accompanies the strobe
  a_r4_keep_with_strobe: assert property (@(posedge clk) disable iff (!por_n)
    (sfr_keep != 2'b00) |-> sfr_rst_stb);

  // R7: brown-out request holds the core in reset
  a_r7_bod_holds: assert property (@(posedge clk) disable iff (!por_n)
    bod_req |=> core_rst);

  // R9: power-on flag is sticky and never sets again while running
  a_r9_pof_sticky: assert property (@(posedge clk) disable iff (!por_n)
    (pof && !pof_clr) |=> pof);

  a_r9_pof_no_set: assert property (@(posedge clk) disable iff (!por_n)
    !pof |=> !pof);

endmodule

bind rst_source_ctrl rst_source_ctrl_chk #(.QUAL_CLKS(QUAL_CLKS)) u_chk (
  .clk        (clk),
  .por_n      (por_n),
  .pin_sync   (pin_sync),
  .swr_bit    (swr_bit),
  .bod_req    (bod_req),
  .pof_clr    (pof_clr),
  .core_rst   (core_rst),
  .sfr_rst_stb(sfr_rst_stb),
  .sfr_keep   (sfr_keep),
  .pc_load    (pc_load),
  .pof        (pof)
);

// File: tb/rst_source_ctrl_bench.sv
module rst_source_ctrl_bench;

  logic        clk;
  logic        por_n;
  logic        rst_pin;
  logic        swr_bit;
  logic        bod_req;
  logic        pof_clr;
  logic        core_rst;
  logic        sfr_rst_stb;
  logic [1:0]  sfr_keep;
  logic        pc_load;
  logic [15:0] pc_vec;
  logic        pof;

  int n_checks;
  int n_fail;
  bit done;
  logic [1:0] exp_q[$];

  rst_source_ctrl u_rst_source_ctrl (
    .clk        (clk),
    .por_n      (por_n),
    .rst_pin    (rst_pin),
    .swr_bit    (swr_bit),
    .bod_req    (bod_req),
    .pof_clr    (pof_clr),
    .core_rst   (core_rst),
    .sfr_rst_stb(sfr_rst_stb),
    .sfr_keep   (sfr_keep),
    .pc_load    (pc_load),
    .pc_vec     (pc_vec),
    .pof        (pof)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver side: expected event with its preserve mask
  task automatic expect_evt(input logic [1:0] keep);
    exp_q.push_back(keep);
  endtask

  // monitor: every observed load is matched against the queue (R5, R4, R6)
  always @(negedge clk) begin
    if (por_n === 1'b1 && !done) begin
      if (pc_load === 1'b1) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R6 unexpected vector load", 1, 0);
        end else begin
          logic [1:0] k;
          k = exp_q.pop_front();
          check(sfr_keep == k, "R4 keep mask", int'(sfr_keep), int'(k));
          check(pc_vec == 16'h0000, "R5 vector", int'(pc_vec), 0);
          check(sfr_rst_stb && core_rst, "R5 strobe with reset", int'({sfr_rst_stb, core_rst}), 3);
        end
      end else if (sfr_rst_stb === 1'b1) begin
        check(1'b0, "R5 strobe without load", 1, 0);
      end
    end
  end

  // watches core_rst over a window; it must stay low
  task automatic quiet_window(input int n, input string req);
    bit seen;
    seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      tick(1);
      if (core_rst) seen = 1'b1;
    end
    check(!seen, req, int'(seen), 0);
  endtask

  initial begin
    n_checks = 0; n_fail = 0; done = 1'b0;
    por_n = 1'b0; rst_pin = 1'b0; swr_bit = 1'b0; bod_req = 1'b0; pof_clr = 1'b0;
    tick(3);
    check(core_rst == 1'b1, "R8 reset held in power-on", int'(core_rst), 1);
    check(pof == 1'b1, "R8 pof set at power-on", int'(pof), 1);
    check(pc_load == 1'b0, "R8 no load during power-on", int'(pc_load), 0);

    por_n = 1'b1; expect_evt(2'b00);
    tick(1);
    check(core_rst == 1'b1, "R8 reset in event cycle", int'(core_rst), 1);
    tick(1);
    check(core_rst == 1'b0, "R8 release after event", int'(core_rst), 0);
    tick(2);

    // R3 software reset on rising edge only
    swr_bit = 1'b1; expect_evt(2'b11);
    tick(1);
    check(core_rst == 1'b1, "R3 software reset asserted", int'(core_rst), 1);
    tick(1);
    check(core_rst == 1'b0, "R3 software reset one cycle", int'(core_rst), 0);
    quiet_window(8, "R3 level held causes no reset");
    swr_bit = 1'b0; tick(2);
    swr_bit = 1'b1; expect_evt(2'b11); tick(2);
    swr_bit = 1'b0; tick(2);

    // R1 short pulse of 23 clocks
    rst_pin = 1'b1; tick(23); rst_pin = 1'b0;
    quiet_window(6, "R1 23-clock pulse rejected");

    // R1 interrupted pulse restarts the count
    rst_pin = 1'b1; tick(20); rst_pin = 1'b0; tick(2);
    rst_pin = 1'b1; tick(20); rst_pin = 1'b0;
    quiet_window(6, "R1 interrupted pulse rejected");

    // R2 qualified pin, held, then released
    rst_pin = 1'b1; expect_evt(2'b00);
    tick(25);
    check(core_rst == 1'b0, "R2 not yet asserted at 25", int'(core_rst), 0);
    tick(1);
    check(core_rst == 1'b1, "R2 asserted at 26", int'(core_rst), 1);
    tick(10);
    check(core_rst == 1'b1, "R2 held while pin high", int'(core_rst), 1);
    rst_pin = 1'b0;
    tick(2);
    check(core_rst == 1'b1, "R2 still held 2 after fall", int'(core_rst), 1);
    tick(1);
    check(core_rst == 1'b0, "R2 released 3 after fall", int'(core_rst), 0);
    check(pof == 1'b1, "R9 pof unchanged by pin reset", int'(pof), 1);
    tick(2);

    // R7 brown-out hold
    bod_req = 1'b1; expect_evt(2'b00);
    tick(1);
    check(core_rst == 1'b1, "R7 brown-out asserts", int'(core_rst), 1);
    tick(5);
    check(core_rst == 1'b1, "R7 brown-out held", int'(core_rst), 1);
    bod_req = 1'b0;
    tick(1);
    check(core_rst == 1'b0, "R7 brown-out release", int'(core_rst), 0);
    tick(2);

    // R6 same-cycle merge: full reset, one load
    swr_bit = 1'b1; bod_req = 1'b1; expect_evt(2'b00);
    tick(1);
    bod_req = 1'b0;
    tick(1);
    check(core_rst == 1'b0, "R6 merged release", int'(core_rst), 0);
    swr_bit = 1'b0; tick(2);

    // R6 software edge during a held brown-out adds no load
    bod_req = 1'b1; expect_evt(2'b00);
    tick(2); swr_bit = 1'b1; tick(2);
    bod_req = 1'b0; tick(1); swr_bit = 1'b0;
    tick(2);
    check(core_rst == 1'b0, "R6 no extra reset after hold", int'(core_rst), 0);

    // R9 clear, then a reset must not set it again
    pof_clr = 1'b1; tick(1); pof_clr = 1'b0;
    check(pof == 1'b0, "R9 pof cleared", int'(pof), 0);
    bod_req = 1'b1; expect_evt(2'b00); tick(2); bod_req = 1'b0; tick(2);
    check(pof == 1'b0, "R9 pof stays clear after brown-out", int'(pof), 0);

    // R8 power-on again sets the flag
    por_n = 1'b0; tick(2);
    check(pof == 1'b1, "R8 pof set by power-on", int'(pof), 1);
    check(core_rst == 1'b1, "R8 reset during power-on", int'(core_rst), 1);
    exp_q.delete();
    por_n = 1'b1; expect_evt(2'b00);
    tick(3);
    check(exp_q.size() == 0, "R5 all expected events seen", exp_q.size(), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

endmodule